// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block walks a processor through a block transfer between a set of registers and consecutive memory words. A single start pulse hands it a base address, a register-selection mask (one bit per register), one of four addressing modes, a direction (load or store) and a writeback request. It computes the first word address from the mode and the number of selected registers. It then issues one word request per selected register, lowest register first at the lowest address, over a valid/ready handshake. Each request is tagged with the register number it belongs to. When the last word has been accepted the block pulses `done` and, if writeback was asked for, presents the updated base.

The four modes step upward or downward, each either before or after the access. This covers all four stack disciplines: full or empty, ascending or descending. A full-descending stack pops with increment-after and pushes with decrement-before. A full-ascending stack pops with decrement-after and pushes with increment-before. An empty-ascending stack pops with decrement-before and pushes with increment-after. An empty-descending stack pops with increment-before and pushes with decrement-after.

The control is a three-state machine. `IDLE` waits for a start pulse. `ISSUE` drives one request at a time and advances on each accepted beat. `DONE` lasts one cycle and then returns to `IDLE`. The transitions are as follows:
- `IDLE` to `ISSUE` on start with a non-empty mask.
- `IDLE` to `DONE` on start with an empty mask.
- `ISSUE` to `ISSUE` on an accepted beat when registers remain, and `ISSUE` holds while ready is low.
- `ISSUE` to `DONE` on acceptance of the last beat.
- `DONE` to `IDLE` unconditionally.

Top module: `blkx_seq`

## Requirements
- R1: The first address depends on the mode code, with n the number of set mask bits. Code 0 (up-after) starts at base. Code 1 (up-before) starts at base+4. Code 2 (down-after) starts at base−4n+4. Code 3 (down-before) starts at base−4n.
- R2: Beats carry the selected register numbers in strictly increasing order, and each beat's address is the previous beat's address plus 4.
- R3: When writeback is requested, `wb_valid` is high exactly in the `done` cycle. `wb_base` is then base+4n for codes 0 and 1 and base−4n for codes 2 and 3. Without writeback, `wb_valid` stays low.
- R4: While `mem_valid` is high and `mem_ready` is low, the request (`mem_addr`, `reg_idx`, `mem_we`) holds steady and is not dropped.
- R5: `done` is high for exactly one cycle. That cycle is the one following the acceptance of the last beat, and `mem_valid` is low during it.
- R6: An empty mask issues no request. `done` rises in the cycle after start, and the writeback base equals the unchanged base.
- R7: Bits [1:0] of `mem_addr` are always zero, whatever the base.
- R8: A start pulse while `busy` is high is ignored. The running sequence keeps its addresses and registers.
- R9: `mem_we` is the inverse of `is_load` captured at start: 1 for a store, 0 for a load.
- R10: After reset, `busy`, `mem_valid`, `done` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE) |
| base | input | AW (32) | Base address |
| reg_mask | input | NREG (16) | Register selection, bit i selects register i |
| mode | input | 2 | 0 up-after, 1 up-before, 2 down-after, 3 down-before |
| is_load | input | 1 | 1 load, 0 store |
| wb_en | input | 1 | Request updated base |
| busy | output | 1 | Sequence in progress |
| mem_valid | output | 1 | Request present |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | AW (32) | Word address of request |
| mem_we | output | 1 | Request is a store |
| reg_idx | output | IW (4) | Register number of this beat |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback base is valid |
| wb_base | output | AW (32) | Updated base |

## Verification
The bench sweeps all four modes across many masks. These include the empty mask, single registers at both ends of the list, the full list and sparse patterns, with both directions, with and without writeback, and with irregular ready stalls.

Several wrong designs would be caught this way:
- A design that counts the down modes from the wrong end would be off by one word in every down-mode address.
- One that reverses register order for down modes would issue the register numbers in descending order.
- One that advances on a stalled beat would skip a register.
- An empty mask that still entered the issue state would produce a spurious request.

A start pulse driven in the middle of a run, with a different base, checks that a restarting design is caught. Unaligned bases check that address bits [1:0] are masked off.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
    typedef enum logic [1:0] {
        MODE_UP_AFTER   = 2'd0,
        MODE_UP_BEFORE  = 2'd1,
        MODE_DN_AFTER   = 2'd2,
        MODE_DN_BEFORE  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/blkx_count.sv
module blkx_count #(
    parameter int NREG = 16,
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] mask,
    output logic [CW-1:0]   count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CW'(mask[i]);
        end
    end
endmodule

// File: rtl/blkx_addr.sv
module blkx_addr
    import blkx_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  xfer_mode_e    mode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    logic [AW-1:0] span;
    localparam logic [AW-1:0] WORD = AW'(4);

    assign span = AW'(count) << 2;

    always_comb begin
        unique case (mode)
            MODE_UP_AFTER: begin
                first_addr = base;
                final_base = base + span;
            end
            MODE_UP_BEFORE: begin
                first_addr = base + WORD;
                final_base = base + span;
            end
            MODE_DN_AFTER: begin
                first_addr = base - span + WORD;
                final_base = base - span;
            end
            MODE_DN_BEFORE: begin
                first_addr = base - span;
                final_base = base - span;
            end
            default: begin
                first_addr = base;
                final_base = base;
            end
        endcase
    end
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] pending,
    output logic [IW-1:0]   idx,
    output logic [NREG-1:0] remain
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pending[i]) idx = IW'(i);
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_clr
            assign remain[g] = pending[g] && (IW'(g) != idx);
        end
    endgenerate
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
    import blkx_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   base,
    input  logic [NREG-1:0] reg_mask,
    input  logic [1:0]      mode,
    input  logic            is_load,
    input  logic            wb_en,
    output logic            busy,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [IW-1:0]   reg_idx,
    output logic            done,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_base
);
    seq_state_e      st_q;
    logic [AW-1:0]   addr_q;
    logic [NREG-1:0] pend_q;
    logic            we_q;
    logic            wb_q;
    logic [AW-1:0]   fin_q;

    logic [CW-1:0]   cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] next_pend;

    blkx_count #(.NREG(NREG)) u_count (
        .mask  (reg_mask),
        .count (cnt)
    );

    blkx_addr #(.AW(AW), .NREG(NREG)) u_addr (
        .base       (base),
        .count      (cnt),
        .mode       (xfer_mode_e'(mode)),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    blkx_pick #(.NREG(NREG)) u_pick (
        .pending (pend_q),
        .idx     (cur_idx),
        .remain  (next_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            pend_q <= '0;
            we_q   <= 1'b0;
            wb_q   <= 1'b0;
            fin_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= first_addr;
                        pend_q <= reg_mask;
                        we_q   <= ~is_load;
                        wb_q   <= wb_en;
                        fin_q  <= final_base;
                        st_q   <= (reg_mask == '0) ? ST_DONE : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_ready) begin
                        pend_q <= next_pend;
                        addr_q <= addr_q + AW'(4);
                        if (next_pend == '0) st_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_valid = (st_q == ST_ISSUE);
        done      = (st_q == ST_DONE);
        wb_valid  = done && wb_q;
        mem_addr  = {addr_q[AW-1:2], 2'b00};
        mem_we    = we_q;
        reg_idx   = cur_idx;
        wb_base   = fin_q;
    end
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [IW-1:0] reg_idx,
    input logic          done,
    input logic          wb_valid
);
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(reg_idx) && $stable(mem_we));

    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid
            || (reg_idx > $past(reg_idx) && mem_addr == $past(mem_addr) + AW'(4)));

    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid);

    p_wb_in_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || done) |-> busy);
endmodule

bind blkx_seq blkx_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .reg_idx   (reg_idx),
    .done      (done),
    .wb_valid  (wb_valid)
);

// File: tb/tb_blkx_seq.sv
module tb_blkx_seq;
    localparam int AW   = 32;
    localparam int NREG = 16;
    localparam int IW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW-1:0]   base = '0;
    logic [NREG-1:0] reg_mask = '0;
    logic [1:0]      mode = '0;
    logic            is_load = 1'b0;
    logic            wb_en = 1'b0;
    logic            busy, mem_valid, mem_we, done, wb_valid;
    logic            mem_ready = 1'b0;
    logic [AW-1:0]   mem_addr, wb_base;
    logic [IW-1:0]   reg_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    blkx_seq #(.AW(AW), .NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base),
        .reg_mask(reg_mask), .mode(mode), .is_load(is_load), .wb_en(wb_en),
        .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .reg_idx(reg_idx),
        .done(done), .wb_valid(wb_valid), .wb_base(wb_base)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [NREG-1:0] m);
        int c = 0;
        for (int i = 0; i < NREG; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [AW-1:0] first_of(input int md, input logic [AW-1:0] b, input int n);
        case (md)
            0: return b;
            1: return b + 32'd4;
            2: return b - 32'(4 * n) + 32'd4;
            default: return b - 32'(4 * n);
        endcase
    endfunction

    function automatic logic [AW-1:0] fin_of(input int md, input logic [AW-1:0] b, input int n);
        return (md < 2) ? b + 32'(4 * n) : b - 32'(4 * n);
    endfunction

    // Runs one transfer; returns the address of the first beat for example checks.
    task automatic run(input int md, input logic [NREG-1:0] m, input logic [AW-1:0] b,
                       input bit ld, input bit wb, input int seed, input bit poke,
                       output logic [AW-1:0] first_seen);
        int n = popc(m);
        logic [AW-1:0] ea = first_of(md, b, n);
        int bit_i = 0;
        int beats = 0;
        int cyc = 0;
        bit hs_prev = 1'b0;
        first_seen = '1;
        @(negedge clk);
        base = b; reg_mask = m; mode = 2'(md); is_load = ld; wb_en = wb;
        start = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (poke && cyc == 2) begin
                start = 1'b1; base = ~b; reg_mask = ~m; mode = 2'(md ^ 1);
            end else begin
                start = 1'b0; base = b; reg_mask = m; mode = 2'(md);
            end
            if (mem_valid) begin
                while (bit_i < NREG && !m[bit_i]) bit_i++;
                if (beats == 0) first_seen = mem_addr;
                chk(mem_addr == (ea & ~32'd3), "R1/R2/R7/R8 addr", mem_addr, ea & ~32'd3);
                chk(reg_idx == IW'(bit_i), "R2 reg_idx", reg_idx, bit_i);
                chk(mem_we == !ld, "R9 mem_we", mem_we, !ld);
                chk(!done, "R5 done low while issuing", done, 0);
                mem_ready = (((cyc * 7 + seed) % 5) < 3);
                hs_prev = mem_ready;
                if (mem_ready) begin
                    beats++; ea = ea + 32'd4; bit_i++;
                end
            end else if (done) begin
                mem_ready = 1'b0;
                chk(beats == n, "R2/R6 beat count", beats, n);
                chk(hs_prev || (n == 0 && cyc == 0), "R5/R6 done timing", cyc, 0);
                chk(wb_valid == wb, "R3 wb_valid", wb_valid, wb);
                if (wb) chk(wb_base == fin_of(md, b, n), "R3/R6 wb_base", wb_base, fin_of(md, b, n));
                break;
            end else begin
                chk(1'b0, "R5 unexpected idle", 0, 1);
                break;
            end
            cyc++;
            if (cyc > 200) begin
                chk(1'b0, "R5 transfer hung", cyc, n);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0; mem_ready = 1'b0; base = b; reg_mask = m; mode = 2'(md);
        @(negedge clk);
        chk(!done && !busy, "R5 back to idle", {done, busy}, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] fs;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_valid && !done && !wb_valid, "R10 reset outputs",
            {busy, mem_valid, done, wb_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_valid, "R10 idle after reset", {busy, mem_valid}, 0);

        // Worked cases: registers 1..3, words at 0x10 upward.
        run(0, 16'h000E, 32'h10, 1, 1, 0, 0, fs);
        chk(fs == 32'h10, "R1 up-after first", fs, 32'h10);
        run(1, 16'h000E, 32'h10, 1, 1, 1, 0, fs);
        chk(fs == 32'h14, "R1 up-before first", fs, 32'h14);
        run(2, 16'h000E, 32'h24, 1, 1, 2, 0, fs);
        chk(fs == 32'h1C, "R1 down-after first", fs, 32'h1C);
        run(3, 16'h000E, 32'h24, 1, 1, 3, 0, fs);
        chk(fs == 32'h18, "R1 down-before first", fs, 32'h18);

        // R6: empty mask, R7: unaligned base, R8: start while busy.
        run(3, 16'h0000, 32'h40, 0, 1, 0, 0, fs);
        run(1, 16'h8001, 32'h103, 0, 1, 4, 0, fs);
        run(2, 16'hFFFF, 32'h200, 1, 1, 2, 1, fs);

        for (int md = 0; md < 4; md++) begin
            for (int k = 0; k < 40; k++) begin
                logic [NREG-1:0] m;
                if (k < 16) m = NREG'(1) << k;
                else if (k == 16) m = '1;
                else if (k == 17) m = '0;
                else m = NREG'((k * 16'h2C5B) ^ (k << 9));
                run(md, m, 32'h1000 + 32'(k * 13), k[0], k[1], k + md, (k % 7) == 3, fs);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule